// File: doc/BRIEF.md
# SDRAM Burst and Latency Sequencer

This block models the device side of a simplified single-bank synchronous DRAM. It keeps a 10-bit mode register and uses it to run read and write bursts against a small internal array of words. A controller drives a decoded command each clock, along with an address and write data. A mode-load command writes the register from the address bus. A read or write command starts a burst at the column on the address bus. Read words come back after a programmed CAS latency, each with an output-enable.

The mode register sets four things: the burst length (1, 2, 4 or 8), the order of addresses within a burst, the read latency (2 or 3 clocks), and whether writes run as bursts or store a single word. If a mode value is unsupported, the block raises an error flag and takes no reads or writes until a valid mode is loaded.

Top module: `sdram_burst_seq`

## Requirements
- R1: After synchronous reset, `rd_oe` and `mode_err` are 0 and `rd_data` is 0. The mode is burst length 1, sequential order, latency 2 and burst writes, so a read returns one word after 2 clocks.
- R2: `cmd` encodes 00 no-op, 01 mode load, 10 read and 11 write. A mode load that is not ignored under R10 copies `addr[9:0]` into the mode register, and later commands use the new value. Mode fields: bits [2:0] burst length code (000=1, 001=2, 010=4, 011=8), bit [3] order (0 sequential, 1 interleaved), bits [6:4] latency code (010=2, 011=3), bits [8:7] operating mode (must be 00), bit [9] single-word writes.
- R3: In sequential order, burst word k uses a column whose low log2(BL) bits are (start + k) mod BL. The column bits above those stay equal to the start column.
- R4: For a read sampled at clock edge n with latency m, `rd_oe` rises after edge n+m-1. The first word is on `rd_data` from then until edge n+m, where it is valid.
- R5: In interleaved order, the low log2(BL) bits of the column for word k are the start bits XOR k. The upper bits stay fixed.
- R6: A read burst gives one word per clock for BL consecutive clocks with `rd_oe` high. `rd_oe` falls in the clock after the last word.
- R7: When bit 9 is 0, a write sampled at edge n stores the `wr_data` sampled at edge n+k into burst column k, for every k below BL, in the order of R3/R5.
- R8: When bit 9 is 1, a write stores only the word given with the command, at the start column. `wr_data` in the following clocks is not stored, and reads still use the full burst length.
- R9: `mode_err` is 1 while the mode has a burst length code above 011, a latency code other than 010 or 011, or nonzero bits [8:7]. Read and write commands are ignored while it is 1: no `rd_oe` and no change to the array.
- R10: The block is busy from the edge that takes a read or write until its last burst word has been issued and the latency pipeline holds no valid word. Any read, write or mode-load command sampled while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Decoded command (R2 encoding) |
| addr | input | ADDR_W (10) | Start column in low COL_W bits, or mode value on a mode load |
| wr_data | input | DW (16) | Write data, one word per burst clock |
| rd_data | output | DW (16) | Read data, zero when not driven |
| rd_oe | output | 1 | High while `rd_data` carries a burst word |
| mode_err | output | 1 | Current mode value is unsupported |

## Verification
A read sampled at edge n shows nothing in the m-1 clocks after n. Its word k is presented after edge n+m-1+k. The bench drives commands at the falling edge and counts falling edges after the command edge, so it checks `rd_oe` and `rd_data` in the half cycle that follows each due edge. It also checks the quiet half cycles on either side of the burst. Write effects show up only at the read port, so every write is followed by a read burst over the same columns. The expected words come from a model array that the bench updates from R7 and R8. `mode_err` is due one edge after a mode load, and the bench checks it at the next falling edge.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int MODE_W = 10;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_LOAD  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } cmd_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] blen;
        logic [1:0] lat;
        logic       ilv;
        logic       wr_one;
    } mode_dec_t;

    localparam logic [MODE_W-1:0] MODE_RESET = 10'h020;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d.ok     = 1'b1;
        d.ilv    = m[3];
        d.wr_one = m[9];
        case (m[2:0])
            3'b000:  d.blen = 4'd1;
            3'b001:  d.blen = 4'd2;
            3'b010:  d.blen = 4'd4;
            3'b011:  d.blen = 4'd8;
            default: begin d.blen = 4'd1; d.ok = 1'b0; end
        endcase
        case (m[6:4])
            3'b010:  d.lat = 2'd2;
            3'b011:  d.lat = 2'd3;
            default: begin d.lat = 2'd2; d.ok = 1'b0; end
        endcase
        if (m[8:7] != 2'b00) d.ok = 1'b0;
        return d;
    endfunction

    function automatic logic [2:0] burst_low(input logic [2:0] s, input logic [2:0] k,
                                             input logic [3:0] blen, input logic ilv);
        logic [2:0] mask;
        logic [2:0] step;
        mask = 3'(blen - 4'd1);
        step = ilv ? (s ^ k) : 3'(s + k);
        return (s & ~mask) | (step & mask);
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] value,
    output logic [MODE_W-1:0] mode_q,
    output mode_dec_t         dec
);
    always_ff @(posedge clk) begin
        if (rst)       mode_q <= MODE_RESET;
        else if (load) mode_q <= value;
    end

    always_comb dec = decode_mode(mode_q);
endmodule

// File: rtl/sdram_burst_ctl.sv
module sdram_burst_ctl
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             go_rd,
    input  logic [COL_W-1:0] go_col,
    input  logic [3:0]       go_len,
    input  logic             go_ilv,
    output logic             issue_rd,
    output logic             issue_wr,
    output logic [COL_W-1:0] col,
    output logic             active
);
    logic             rd_q;
    logic [2:0]       idx_q;
    logic [COL_W-1:0] base_q;
    logic [3:0]       len_q;
    logic             ilv_q;

    always_comb begin
        if (go) col = go_col;
        else    col = {base_q[COL_W-1:3], burst_low(base_q[2:0], idx_q, len_q, ilv_q)};
        issue_rd = (go && go_rd)  || (active && rd_q);
        issue_wr = (go && !go_rd) || (active && !rd_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            rd_q   <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            len_q  <= 4'd1;
            ilv_q  <= 1'b0;
        end else if (go) begin
            active <= (go_len > 4'd1);
            rd_q   <= go_rd;
            idx_q  <= 3'd1;
            base_q <= go_col;
            len_q  <= go_len;
            ilv_q  <= go_ilv;
        end else if (active) begin
            if (idx_q == 3'(len_q - 4'd1)) active <= 1'b0;
            idx_q <= idx_q + 3'd1;
        end
    end
endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe #(
    parameter int DW     = 16,
    parameter int MAX_CL = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [DW-1:0] in_dat,
    input  logic [1:0]    lat,
    output logic          out_vld,
    output logic [DW-1:0] out_dat,
    output logic          busy
);
    localparam int DEPTH = MAX_CL - 1;
    localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_q;
    logic [DW-1:0]    dat_q [DEPTH];
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel  = SEL_W'(lat - 2'd2);
        busy = |vld_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
        end else begin
            vld_q[0] <= in_vld;
            dat_q[0] <= in_dat;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= vld_q[sel];
            out_dat <= vld_q[sel] ? dat_q[sel] : '0;
        end
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int COL_W  = 6,
    parameter int DW     = 16,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              rd_oe,
    output logic              mode_err
);
    localparam int WORDS = 1 << COL_W;

    cmd_e              cmd_v;
    mode_dec_t         md;
    logic [MODE_W-1:0] mode_q;
    logic              busy, load, go, go_rd;
    logic [3:0]        go_len;
    logic              issue_rd, issue_wr, eng_active, pipe_busy;
    logic [COL_W-1:0]  col;
    logic [DW-1:0]     mem_q [WORDS];

    always_comb begin
        cmd_v    = cmd_e'(cmd);
        busy     = eng_active || pipe_busy;
        load     = (cmd_v == CMD_LOAD) && !busy;
        go_rd    = (cmd_v == CMD_READ);
        go       = !busy && md.ok && ((cmd_v == CMD_READ) || (cmd_v == CMD_WRITE));
        go_len   = (!go_rd && md.wr_one) ? 4'd1 : md.blen;
        mode_err = !md.ok;
    end

    sdram_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .value  (addr[MODE_W-1:0]),
        .mode_q (mode_q),
        .dec    (md)
    );

    sdram_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .go_rd    (go_rd),
        .go_col   (addr[COL_W-1:0]),
        .go_len   (go_len),
        .go_ilv   (md.ilv),
        .issue_rd (issue_rd),
        .issue_wr (issue_wr),
        .col      (col),
        .active   (eng_active)
    );

    always_ff @(posedge clk) begin
        if (issue_wr) mem_q[col] <= wr_data;
    end

    sdram_lat_pipe #(.DW(DW), .MAX_CL(MAX_CL)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (issue_rd),
        .in_dat  (mem_q[col]),
        .lat     (md.lat),
        .out_vld (rd_oe),
        .out_dat (rd_data),
        .busy    (pipe_busy)
    );
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
    parameter int COL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             go_rd,
    input logic [1:0]       lat,
    input logic             mode_err,
    input logic             rd_oe,
    input logic             busy,
    input logic [9:0]       mode_q,
    input logic             eng_active,
    input logic [COL_W-1:0] col
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)        run_q <= '0;
        else if (rd_oe) run_q <= run_q + 4'd1;
        else            run_q <= '0;
    end

    // R4: first word enable two or three edges after the read edge
    a_r4_cl2_first: assert property (@(posedge clk) disable iff (rst)
        (go && go_rd && lat == 2'd2) |-> ##2 rd_oe);
    a_r4_cl3_first: assert property (@(posedge clk) disable iff (rst)
        (go && go_rd && lat == 2'd3) |-> ##3 rd_oe);
    // R6: an enable run never exceeds eight words
    a_r6_run_max: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> (run_q < 4'd8));
    // R9: no read data starts while the mode is flagged
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> !$rose(rd_oe));
    // R10: mode register frozen while busy
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));
    // R3: upper column bits fixed across a burst
    a_r3_block_fixed: assert property (@(posedge clk) disable iff (rst)
        eng_active |-> (col[COL_W-1:3] == $past(col[COL_W-1:3])));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .go_rd      (go_rd),
    .lat        (md.lat),
    .mode_err   (mode_err),
    .rd_oe      (rd_oe),
    .busy       (busy),
    .mode_q     (mode_q),
    .eng_active (eng_active),
    .col        (col)
);

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;
    import sdram_seq_pkg::*;

    typedef struct packed {
        logic [9:0]  mode;
        logic [5:0]  start;
        logic [1:0]  lat;
        logic [3:0]  len;
        logic        ilv;
        logic [47:0] cols;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'h022, 6'd13, 2'd2, 4'd4, 1'b0, {6'd0, 6'd0, 6'd0, 6'd0, 6'd12, 6'd15, 6'd14, 6'd13}},
        '{10'h03A, 6'd13, 2'd3, 4'd4, 1'b1, {6'd0, 6'd0, 6'd0, 6'd0, 6'd14, 6'd15, 6'd12, 6'd13}},
        '{10'h033, 6'd21, 2'd3, 4'd8, 1'b0, {6'd20, 6'd19, 6'd18, 6'd17, 6'd16, 6'd23, 6'd22, 6'd21}},
        '{10'h02B, 6'd42, 2'd2, 4'd8, 1'b1, {6'd45, 6'd44, 6'd47, 6'd46, 6'd41, 6'd40, 6'd43, 6'd42}},
        '{10'h021, 6'd7,  2'd2, 4'd2, 1'b0, {6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd6, 6'd7}},
        '{10'h039, 6'd30, 2'd3, 4'd2, 1'b1, {6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd31, 6'd30}},
        '{10'h030, 6'd63, 2'd3, 4'd1, 1'b0, {6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd63}},
        '{10'h023, 6'd0,  2'd2, 4'd8, 1'b0, {6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1, 6'd0}}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = CMD_NOP;
    logic [9:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_oe;
    logic        mode_err;

    logic [15:0] model [64];
    int          n_run = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    sdram_burst_seq uut (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_oe    (rd_oe),
        .mode_err (mode_err)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_mode(input logic [9:0] m);
        @(negedge clk); cmd = CMD_LOAD; addr = m;
        @(negedge clk); cmd = CMD_NOP;
    endtask

    task automatic run_read(input logic [5:0] start, input int lat, input int len,
                            input logic [47:0] cols, input string tag);
        @(negedge clk); cmd = CMD_READ; addr = {4'd0, start};
        @(negedge clk); cmd = CMD_NOP;
        for (int j = 0; j <= lat + len; j++) begin
            logic exp_oe;
            if (j > 0) @(negedge clk);
            exp_oe = (j >= lat - 1) && (j < lat - 1 + len);
            check(rd_oe == exp_oe, {tag, " R4/R6 enable"}, 16'(rd_oe), 16'(exp_oe));
            if (exp_oe) begin
                logic [5:0] c;
                c = cols[6*(j-lat+1) +: 6];
                check(rd_data == model[c], {tag, " data"}, rd_data, model[c]);
            end
        end
        idle(3);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_oe == 1'b0, "R1 oe", 16'(rd_oe), 16'd0);
        check(rd_data == 16'd0, "R1 data", rd_data, 16'd0);
        check(mode_err == 1'b0, "R1 err", 16'(mode_err), 16'd0);

        // fill the array with single writes under the reset mode (R1, R2)
        for (int c = 0; c < 64; c++) begin
            cmd = CMD_WRITE; addr = 10'(c); wr_data = 16'hC300 | 16'(c);
            model[c] = 16'hC300 | 16'(c);
            @(negedge clk);
        end
        cmd = CMD_NOP;
        idle(2);
        run_read(6'd5, 2, 1, 48'd5, "R1");

        // table of modes and burst orders: R2 R3 R5
        for (int v = 0; v < NV; v++) begin
            load_mode(VECS[v].mode);
            check(mode_err == 1'b0, "R2 valid mode", 16'(mode_err), 16'd0);
            run_read(VECS[v].start, int'(VECS[v].lat), int'(VECS[v].len), VECS[v].cols,
                     VECS[v].ilv ? "R5" : "R3");
        end

        // R7: burst write, sequential BL4, start 50 -> cols 50,51,48,49
        load_mode(10'h022);
        @(negedge clk); cmd = CMD_WRITE; addr = 10'd50; wr_data = 16'h7000;
        @(negedge clk); cmd = CMD_NOP; wr_data = 16'h7001;
        @(negedge clk); wr_data = 16'h7002;
        @(negedge clk); wr_data = 16'h7003;
        model[50] = 16'h7000; model[51] = 16'h7001; model[48] = 16'h7002; model[49] = 16'h7003;
        idle(3);
        run_read(6'd48, 2, 4, {6'd0, 6'd0, 6'd0, 6'd0, 6'd51, 6'd50, 6'd49, 6'd48}, "R7");

        // R8: single-location write, reads still BL4
        load_mode(10'h222);
        @(negedge clk); cmd = CMD_WRITE; addr = 10'd56; wr_data = 16'hE000;
        @(negedge clk); cmd = CMD_NOP; wr_data = 16'hE001;
        @(negedge clk); wr_data = 16'hE002;
        @(negedge clk); wr_data = 16'hE003;
        model[56] = 16'hE000;
        idle(3);
        run_read(6'd56, 2, 4, {6'd0, 6'd0, 6'd0, 6'd0, 6'd59, 6'd58, 6'd57, 6'd56}, "R8");

        // R9: reserved operating mode, bad latency, bad burst length
        load_mode(10'h0A2);
        check(mode_err == 1'b1, "R9 opmode flag", 16'(mode_err), 16'd1);
        @(negedge clk); cmd = CMD_READ; addr = 10'd0;
        @(negedge clk); cmd = CMD_WRITE; addr = 10'd0; wr_data = 16'hFFFF;
        @(negedge clk); cmd = CMD_NOP;
        for (int j = 0; j < 6; j++) begin
            check(rd_oe == 1'b0, "R9 no read", 16'(rd_oe), 16'd0);
            @(negedge clk);
        end
        load_mode(10'h042);
        check(mode_err == 1'b1, "R9 latency flag", 16'(mode_err), 16'd1);
        load_mode(10'h024);
        check(mode_err == 1'b1, "R9 length flag", 16'(mode_err), 16'd1);
        load_mode(10'h020);
        check(mode_err == 1'b0, "R9 cleared", 16'(mode_err), 16'd0);
        run_read(6'd0, 2, 1, 48'd0, "R9");

        // R10: commands during a CL3 BL8 read are ignored
        load_mode(10'h033);
        @(negedge clk); cmd = CMD_READ; addr = 10'd8;
        @(negedge clk); cmd = CMD_NOP;
        for (int j = 0; j <= 11; j++) begin
            logic exp_oe;
            if (j > 0) @(negedge clk);
            exp_oe = (j >= 2) && (j < 10);
            check(rd_oe == exp_oe, "R10 enable", 16'(rd_oe), 16'(exp_oe));
            if (exp_oe)
                check(rd_data == model[6'(8 + j - 2)], "R10 data", rd_data, model[6'(8 + j - 2)]);
            if (j == 2) begin cmd = CMD_WRITE; addr = 10'd9; wr_data = 16'hBEEF; end
            else if (j == 4) begin cmd = CMD_LOAD; addr = 10'h020; end
            else cmd = CMD_NOP;
        end
        cmd = CMD_NOP;
        idle(3);
        run_read(6'd9, 3, 8, {6'd8, 6'd15, 6'd14, 6'd13, 6'd12, 6'd11, 6'd10, 6'd9}, "R10");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule